// File: doc/BRIEF.md
# Transmit Descriptor Ring Fetch Engine

This block is the sequencer behind a network transmitter. When a poll request arrives, it walks a ring of descriptors in memory, starting at its current descriptor pointer. Each descriptor is eight 32-bit words (32 bytes). Word 0 holds control and status. Word 1 holds two segment lengths: buffer A in the low half and buffer B in the high half. Word 2 holds the address of buffer A. The remaining words are not read.

For each descriptor that software has handed over, the engine reads buffer A one word at a time and sends its bytes out on a byte stream. It then returns the descriptor to software by writing word 0 back with the ownership flag cleared. Finally it moves its pointer to the next slot, or back to the ring start. A scan ends at the first descriptor software still holds. A scan also stops on a descriptor with an illegal length, which is left untouched.

The memory side is a single request port with one outstanding access. The request is held until it is acknowledged, and read data comes back with the acknowledge. Bytes leave on a valid/ready stream, and the last byte of a frame is flagged.

Top module: `tx_ring_fetch`

## Requirements
- R1: After reset, `busy`, `mem_req`, `out_valid` and `frame_done` are low and `cur_ptr` is zero.
- R2: A `kick` pulse while idle starts a scan. `busy` rises on the next cycle and the first request reads word 0 at `cur_ptr`. `busy` stays high until the scan ends.
- R3: A fetched word 0 with bit 31 (handed-over flag) clear ends the scan. No write is made and `cur_ptr` is unchanged.
- R4: The buffer A bytes are streamed in ascending address order from the byte address in word 2, which may be unaligned. Within a word, bit lane 8k holds the byte at offset k. Exactly as many bytes are sent as the buffer A length.
- R5: When bit 29 of word 0 (frame end) is set, `out_last` marks the final byte of that segment. `frame_done` pulses once after its write-back.
- R6: After a descriptor is consumed, word 0 is written back to the descriptor's own address with bit 31 cleared and every other bit unchanged.
- R7: After the write-back, `cur_ptr` reloads from `ring_base` when bit 21 of word 0 (ring end) is set. Otherwise it advances by 32.
- R8: A buffer A length above 2048 stops the scan before the buffer is read. The descriptor is not written and the pointer does not move. A length of exactly 2048 is accepted.
- R9: A non-zero buffer B length stops the scan in the same way as R8.
- R10: The lengths of the segments of one frame are summed within a scan. A segment that would bring the sum to 8192 or more stops the scan in the same way as R8. A sum of 8191 is accepted.
- R11: One or more `kick` pulses that arrive during a scan cause exactly one further scan after it.
- R12: A `base_set` pulse copies `ring_base` into `cur_ptr`.
- R13: Only the low 12 bits of each length field count. Bits 15:12 and 31:28 of word 1 are ignored.
- R14: A memory request keeps its address, direction and write data stable until acknowledged. A byte offered on the stream stays stable until it is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous-free active-low reset, sampled on the clock |
| kick | input | 1 | Poll request pulse |
| base_set | input | 1 | Load `ring_base` into the current pointer |
| ring_base | input | AW | Byte address of the first ring slot |
| cur_ptr | output | AW | Current descriptor pointer |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | AW | Word-aligned byte address |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Access accepted; read data valid |
| mem_rdata | input | 32 | Read data |
| out_valid | output | 1 | Byte available |
| out_ready | input | 1 | Byte taken when high with `out_valid` |
| out_data | output | 8 | Frame byte |
| out_last | output | 1 | Final byte of a frame |
| busy | output | 1 | Scan in progress |
| frame_done | output | 1 | One-cycle pulse per finished frame |

## Verification
The checker assumes that `mem_ack` only answers a pending request, and never in the same cycle the request first appears. It also assumes that `ring_base` is stable and `base_set` is only pulsed while idle, so every pointer change is either a 32-byte step or a return to the ring start. The bench's memory model acknowledges one cycle after it sees a request and then drops the acknowledge for a cycle. The bench drives `base_set` and rewrites descriptors only while `busy` is low. Ready is either held high or throttled in a fixed pattern, so both the held-byte and free-running cases occur.

// File: rtl/tx_ring_pkg.sv
package tx_ring_pkg;
   localparam int unsigned DESC_WORDS = 8;
   localparam int unsigned W_CTL      = 0;
   localparam int unsigned W_SIZE     = 1;
   localparam int unsigned W_BUFA     = 2;
   localparam int unsigned OWN_BIT    = 31;
   localparam int unsigned LAST_BIT   = 29;
   localparam int unsigned WRAP_BIT   = 21;
   localparam int unsigned SEGB_LSB   = 16;

   typedef enum logic [2:0] {
      S_IDLE, S_CTL, S_SIZE, S_BUFA, S_DATA, S_EMIT, S_WBACK
   } fetch_st_t;
endpackage

// File: rtl/tx_ring_ptr.sv
module tx_ring_ptr #(
   parameter int unsigned AW         = 32,
   parameter int unsigned DESC_BYTES = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [AW-1:0] base,
   input  logic          step,
   input  logic          wrap,
   output logic [AW-1:0] ptr
);
   localparam logic [AW-1:0] STRIDE = AW'(DESC_BYTES);

   always_ff @(posedge clk) begin
      if (!rst_n)      ptr <= '0;
      else if (load)   ptr <= base;
      else if (step)   ptr <= wrap ? base : ptr + STRIDE;
   end
endmodule

// File: rtl/tx_seg_check.sv
module tx_seg_check #(
   parameter int unsigned SZW       = 12,
   parameter int unsigned MAX_SEG   = 2048,
   parameter int unsigned MAX_FRAME = 8192
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           clear,
   input  logic           add,
   input  logic [SZW-1:0] add_len,
   input  logic [SZW-1:0] seg_a,
   input  logic [SZW-1:0] seg_b,
   output logic           seg_ok
);
   localparam int unsigned ACCW = $clog2(MAX_FRAME) + 1;
   localparam logic [SZW-1:0] SEG_LIM   = SZW'(MAX_SEG);
   localparam logic [ACCW:0]  FRAME_LIM = (ACCW+1)'(MAX_FRAME);

   logic [ACCW-1:0] acc_q;
   logic [ACCW:0]   sum;

   assign sum    = {1'b0, acc_q} + (ACCW+1)'(seg_a);
   assign seg_ok = (seg_a <= SEG_LIM) && (seg_b == '0) && (sum < FRAME_LIM);

   always_ff @(posedge clk) begin
      if (!rst_n)     acc_q <= '0;
      else if (clear) acc_q <= '0;
      else if (add)   acc_q <= acc_q + ACCW'(add_len);
   end
endmodule

// File: rtl/tx_byte_lane.sv
module tx_byte_lane #(
   parameter int unsigned SZW        = 12,
   parameter bit          LITTLE_END = 1'b1
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           set_seg,
   input  logic [SZW-1:0] seg_len,
   input  logic [1:0]     start_lane,
   input  logic           load_word,
   input  logic [31:0]    word_in,
   input  logic           take,
   output logic [7:0]     byte_out,
   output logic           lane_last,
   output logic           rem_one
);
   logic [31:0]    word_q;
   logic [1:0]     lane_q;
   logic [SZW-1:0] rem_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         word_q <= '0;
         lane_q <= '0;
         rem_q  <= '0;
      end else begin
         if (load_word) word_q <= word_in;
         if (set_seg) begin
            rem_q  <= seg_len;
            lane_q <= start_lane;
         end else if (take) begin
            rem_q  <= rem_q - SZW'(1);
            lane_q <= lane_q + 2'd1;
         end
      end
   end

   generate
      if (LITTLE_END) begin : g_le
         always_comb byte_out = word_q[8*lane_q +: 8];
      end else begin : g_be
         always_comb byte_out = word_q[8*(3-lane_q) +: 8];
      end
   endgenerate

   assign lane_last = (lane_q == 2'd3);
   assign rem_one   = (rem_q == SZW'(1));
endmodule

// File: rtl/tx_ring_fetch.sv
module tx_ring_fetch
   import tx_ring_pkg::*;
#(
   parameter int unsigned AW         = 32,
   parameter int unsigned SZW        = 12,
   parameter int unsigned MAX_SEG    = 2048,
   parameter int unsigned MAX_FRAME  = 8192,
   parameter bit          LITTLE_END = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          kick,
   input  logic          base_set,
   input  logic [AW-1:0] ring_base,
   output logic [AW-1:0] cur_ptr,
   output logic          mem_req,
   output logic          mem_we,
   output logic [AW-1:0] mem_addr,
   output logic [31:0]   mem_wdata,
   input  logic          mem_ack,
   input  logic [31:0]   mem_rdata,
   output logic          out_valid,
   input  logic          out_ready,
   output logic [7:0]    out_data,
   output logic          out_last,
   output logic          busy,
   output logic          frame_done
);
   localparam int unsigned DESC_BYTES = DESC_WORDS * 4;
   localparam logic [31:0] OWN_MASK   = 32'(1) << OWN_BIT;

   generate
      if (AW < 8 || AW > 32) begin : g_bad_aw
         $error("AW must lie in 8..32");
      end
      if (SZW > 16 || (1 << SZW) <= MAX_SEG) begin : g_bad_szw
         $error("length field too narrow or too wide");
      end
      if (MAX_SEG >= MAX_FRAME) begin : g_bad_lim
         $error("segment limit must be below frame limit");
      end
   endgenerate

   fetch_st_t      st;
   logic [31:0]    ctl_q;
   logic [SZW-1:0] len_q;
   logic [AW-1:0]  waddr_q;
   logic           pend_q, done_q;
   logic           start, seg_ok, lane_last, rem_one, wb_ack;

   assign start  = kick | pend_q;
   assign wb_ack = (st == S_WBACK) && mem_ack;

   tx_ring_ptr #(.AW(AW), .DESC_BYTES(DESC_BYTES)) u_ptr (
      .clk(clk), .rst_n(rst_n), .load(base_set), .base(ring_base),
      .step(wb_ack), .wrap(ctl_q[WRAP_BIT]), .ptr(cur_ptr));

   tx_seg_check #(.SZW(SZW), .MAX_SEG(MAX_SEG), .MAX_FRAME(MAX_FRAME)) u_chk_len (
      .clk(clk), .rst_n(rst_n),
      .clear((st == S_IDLE && start) || (wb_ack && ctl_q[LAST_BIT])),
      .add(wb_ack && !ctl_q[LAST_BIT]), .add_len(len_q),
      .seg_a(mem_rdata[SZW-1:0]), .seg_b(mem_rdata[SEGB_LSB +: SZW]),
      .seg_ok(seg_ok));

   tx_byte_lane #(.SZW(SZW), .LITTLE_END(LITTLE_END)) u_lane (
      .clk(clk), .rst_n(rst_n),
      .set_seg((st == S_BUFA) && mem_ack), .seg_len(len_q),
      .start_lane(mem_rdata[1:0]),
      .load_word((st == S_DATA) && mem_ack), .word_in(mem_rdata),
      .take((st == S_EMIT) && out_ready),
      .byte_out(out_data), .lane_last(lane_last), .rem_one(rem_one));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st      <= S_IDLE;
         ctl_q   <= '0;
         len_q   <= '0;
         waddr_q <= '0;
         pend_q  <= 1'b0;
         done_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (kick && st != S_IDLE) pend_q <= 1'b1;
         unique case (st)
            S_IDLE: if (start) begin
               pend_q <= 1'b0;
               st     <= S_CTL;
            end
            S_CTL: if (mem_ack) begin
               ctl_q <= mem_rdata;
               st    <= mem_rdata[OWN_BIT] ? S_SIZE : S_IDLE;
            end
            S_SIZE: if (mem_ack) begin
               if (seg_ok) begin
                  len_q <= mem_rdata[SZW-1:0];
                  st    <= (mem_rdata[SZW-1:0] == '0) ? S_WBACK : S_BUFA;
               end else begin
                  st <= S_IDLE;
               end
            end
            S_BUFA: if (mem_ack) begin
               waddr_q <= mem_rdata[AW-1:0];
               st      <= S_DATA;
            end
            S_DATA: if (mem_ack) begin
               waddr_q <= waddr_q + AW'(4);
               st      <= S_EMIT;
            end
            S_EMIT: if (out_ready) begin
               if (rem_one)        st <= S_WBACK;
               else if (lane_last) st <= S_DATA;
            end
            S_WBACK: if (mem_ack) begin
               done_q <= ctl_q[LAST_BIT];
               st     <= S_CTL;
            end
            default: st <= S_IDLE;
         endcase
      end
   end

   always_comb begin
      mem_addr = cur_ptr;
      unique case (st)
         S_SIZE:  mem_addr = cur_ptr + AW'(4 * W_SIZE);
         S_BUFA:  mem_addr = cur_ptr + AW'(4 * W_BUFA);
         S_DATA:  mem_addr = {waddr_q[AW-1:2], 2'b00};
         default: mem_addr = cur_ptr + AW'(4 * W_CTL);
      endcase
   end

   assign mem_req    = (st != S_IDLE) && (st != S_EMIT);
   assign mem_we     = (st == S_WBACK);
   assign mem_wdata  = ctl_q & ~OWN_MASK;
   assign out_valid  = (st == S_EMIT);
   assign out_last   = (st == S_EMIT) && rem_one && ctl_q[LAST_BIT];
   assign busy       = (st != S_IDLE);
   assign frame_done = done_q;
endmodule

// File: rtl/tx_ring_fetch_chk.sv
module tx_ring_fetch_chk #(
   parameter int unsigned AW = 32
) (
   input logic          clk,
   input logic          rst_n,
   input logic          kick,
   input logic          base_set,
   input logic [AW-1:0] ring_base,
   input logic [AW-1:0] cur_ptr,
   input logic          mem_req,
   input logic          mem_we,
   input logic [AW-1:0] mem_addr,
   input logic [31:0]   mem_wdata,
   input logic          mem_ack,
   input logic          out_valid,
   input logic          out_ready,
   input logic [7:0]    out_data,
   input logic          out_last,
   input logic          busy,
   input logic          frame_done
);
   a_r2_kick_starts: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && kick) |=> busy);

   a_r3_stream_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid || mem_req) |-> busy);

   a_r5_last_on_byte: assert property (@(posedge clk) disable iff (!rst_n)
      out_last |-> out_valid);

   a_r5_done_in_scan: assert property (@(posedge clk) disable iff (!rst_n)
      frame_done |-> busy);

   a_r6_wb_owner_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_we) |-> !mem_wdata[31]);

   a_r7_ptr_moves: assert property (@(posedge clk) disable iff (!rst_n)
      ((cur_ptr != $past(cur_ptr)) && !$past(base_set)) |->
         (cur_ptr == $past(cur_ptr) + AW'(32)) || (cur_ptr == $past(ring_base)));

   a_r14_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack) |=>
         (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

   a_r14_byte_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=>
         (out_valid && $stable(out_data) && $stable(out_last)));
endmodule

bind tx_ring_fetch tx_ring_fetch_chk #(.AW(AW)) u_chk (.*);

// File: tb/tx_ring_fetch_tb.sv
module tx_ring_fetch_tb;
   localparam int CLK_PERIOD = 10;
   localparam int MEM_WORDS  = 4096;
   localparam int WD_LIMIT   = 190000;
   localparam logic [31:0] RING = 32'h100;
   localparam logic [31:0] BUF  = 32'h1000;
   localparam logic [31:0] OWN  = 32'h8000_0000;
   localparam logic [31:0] LAST = 32'h2000_0000;
   localparam logic [31:0] WRAP = 32'h0020_0000;
   localparam logic [31:0] MARK = 32'h0000_0A5C;
   // vector: [31] ring end, [30] throttle ready, [29:28] byte offset,
   //         [27:16] buffer A length, [15:12] junk in length word
   localparam logic [31:0] VEC [0:5] = '{
      32'h0001_0000, 32'h0004_0000, 32'h700D_0000,
      32'h9040_0000, 32'h2010_F000, 32'h0800_0000 };

   logic clk = 1'b0, rst_n = 1'b0, kick = 1'b0, base_set = 1'b0;
   logic [31:0] ring_base = '0;
   logic [31:0] cur_ptr, mem_addr, mem_wdata, mem_rdata;
   logic mem_req, mem_we, mem_ack, out_valid, out_ready, out_last, busy, frame_done;
   logic [7:0] out_data;

   logic [31:0] mem [0:MEM_WORDS-1];
   int tests = 0, fails = 0;
   int cap_n, mism, last_cnt, last_idx, done_cnt, wr_cnt, watch_cnt, cyc = 0;
   logic [31:0] exp_base, watch_addr = 32'hFFFF_FFFF;
   bit stall_mode = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   tx_ring_fetch u_dut (.*);

   function automatic logic [7:0] pat(input logic [31:0] a);
      return a[7:0] ^ a[15:8] ^ 8'hA5;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         mem_ack <= 1'b0;
         mem_rdata <= '0;
      end else begin
         mem_ack <= 1'b0;
         if (mem_req && !mem_ack) begin
            mem_ack <= 1'b1;
            if (mem_we) begin
               mem[mem_addr[13:2]] <= mem_wdata;
               wr_cnt <= wr_cnt + 1;
            end else begin
               mem_rdata <= mem[mem_addr[13:2]];
               if (mem_addr == watch_addr) watch_cnt <= watch_cnt + 1;
            end
         end
      end
   end

   always @(posedge clk) begin
      if (rst_n && out_valid && out_ready) begin
         if (out_data != pat(exp_base + 32'(cap_n))) mism <= mism + 1;
         if (out_last) begin
            last_cnt <= last_cnt + 1;
            last_idx <= cap_n;
         end
         cap_n <= cap_n + 1;
      end
      if (rst_n && frame_done) done_cnt <= done_cnt + 1;
   end

   always @(negedge clk) begin
      cyc <= cyc + 1;
      out_ready <= stall_mode ? (cyc % 3 != 0) : 1'b1;
   end

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic clear_counts(input logic [31:0] base);
      cap_n = 0; mism = 0; last_cnt = 0; last_idx = -1;
      done_cnt = 0; wr_cnt = 0; watch_cnt = 0; exp_base = base;
   endtask

   task automatic put_desc(input int slot, input logic [31:0] ctl,
                           input logic [31:0] sw, input logic [31:0] ba);
      int w;
      w = (RING + 32'(slot * 32)) >> 2;
      mem[w] = ctl; mem[w+1] = sw; mem[w+2] = ba;
   endtask

   task automatic fresh_ring();
      for (int s = 0; s < 6; s++) put_desc(s, 32'h0, 32'h0, 32'h0);
      @(negedge clk);
      ring_base = RING; base_set = 1'b1;
      @(negedge clk);
      base_set = 1'b0;
   endtask

   task automatic kick_wait();
      kick = 1'b1;
      @(negedge clk);
      kick = 1'b0;
      while (busy) @(negedge clk);
      @(negedge clk);
   endtask

   initial begin
      repeat (WD_LIMIT) @(posedge clk);
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", WD_LIMIT, 0);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      for (int i = 0; i < MEM_WORDS; i++)
         mem[i] = {pat(32'(4*i+3)), pat(32'(4*i+2)), pat(32'(4*i+1)), pat(32'(4*i))};
      clear_counts(BUF);
      repeat (3) @(negedge clk);
      // R1: reset state
      chk(!busy && !mem_req && !out_valid && !frame_done, "R1 reset outputs", busy, 0);
      chk(cur_ptr == 0, "R1 reset pointer", cur_ptr, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R12: base load
      fresh_ring();
      chk(cur_ptr == RING, "R12 base load", cur_ptr, RING);

      // R3: empty ring
      clear_counts(BUF);
      kick_wait();
      chk(cap_n == 0 && wr_cnt == 0, "R3 empty ring no traffic", cap_n + wr_cnt, 0);
      chk(cur_ptr == RING && !busy, "R3 pointer kept", cur_ptr, RING);

      // vector table: R2 R4 R5 R6 R7 R13 R8(boundary)
      for (int v = 0; v < 6; v++) begin
         logic [31:0] e, ctl, ba;
         int sz;
         e = VEC[v];
         sz = int'(e[27:16]);
         ctl = OWN | LAST | (e[31] ? WRAP : 32'h0) | MARK;
         ba = BUF + 32'(e[29:28]);
         fresh_ring();
         stall_mode = e[30];
         put_desc(0, ctl, {e[15:12], 12'h000, e[15:12], e[27:16]}, ba);
         clear_counts(ba);
         kick = 1'b1;
         @(negedge clk);
         kick = 1'b0;
         chk(busy, "R2 busy after kick", busy, 1);
         while (busy) @(negedge clk);
         @(negedge clk);
         stall_mode = 1'b0;
         chk(cap_n == sz && mism == 0, "R4 R13 R8 byte stream", cap_n, sz);
         chk(last_cnt == 1 && last_idx == sz - 1, "R5 last marker", last_idx, sz - 1);
         chk(done_cnt == 1, "R5 frame done pulse", done_cnt, 1);
         chk(mem[RING >> 2] == (ctl & ~OWN), "R6 write-back word", mem[RING >> 2], ctl & ~OWN);
         chk(cur_ptr == (e[31] ? RING : RING + 32), "R7 pointer update", cur_ptr,
             e[31] ? RING : RING + 32);
      end

      // R8: length 2049 halts
      fresh_ring();
      put_desc(0, OWN | LAST, 32'd2049, BUF);
      clear_counts(BUF);
      kick_wait();
      chk(cap_n == 0 && wr_cnt == 0, "R8 oversize no output", cap_n + wr_cnt, 0);
      chk(mem[RING >> 2] == (OWN | LAST) && cur_ptr == RING, "R8 descriptor kept", cur_ptr, RING);

      // R9: buffer B non-zero halts
      fresh_ring();
      put_desc(0, OWN | LAST, 32'h0001_0010, BUF);
      clear_counts(BUF);
      kick_wait();
      chk(cap_n == 0 && wr_cnt == 0, "R9 buffer B halts", cap_n + wr_cnt, 0);
      chk(cur_ptr == RING, "R9 pointer kept", cur_ptr, RING);

      // R10: 2048*3 + 2047 = 8191 accepted
      fresh_ring();
      for (int s = 0; s < 3; s++) put_desc(s, OWN, 32'd2048, BUF + 32'(s * 2048));
      put_desc(3, OWN | LAST, 32'd2047, BUF + 32'd6144);
      clear_counts(BUF);
      kick_wait();
      chk(cap_n == 8191 && mism == 0, "R10 8191-byte frame", cap_n, 8191);
      chk(last_idx == 8190 && done_cnt == 1, "R10 frame end", last_idx, 8190);
      chk(cur_ptr == RING + 128 && wr_cnt == 4, "R10 four consumed", cur_ptr, RING + 128);

      // R10: reaching 8192 halts at the fourth segment
      fresh_ring();
      for (int s = 0; s < 3; s++) put_desc(s, OWN, 32'd2048, BUF + 32'(s * 2048));
      put_desc(3, OWN | LAST, 32'd2048, BUF + 32'd6144);
      clear_counts(BUF);
      kick_wait();
      chk(cap_n == 6144 && done_cnt == 0, "R10 limit halts", cap_n, 6144);
      chk(cur_ptr == RING + 96 && wr_cnt == 3, "R10 halted pointer", cur_ptr, RING + 96);
      chk(mem[(RING + 96) >> 2] == (OWN | LAST), "R10 descriptor kept", mem[(RING + 96) >> 2],
          OWN | LAST);

      // R11: kicks during a scan give exactly one more scan
      fresh_ring();
      put_desc(0, OWN | LAST, 32'd200, BUF);
      clear_counts(BUF);
      watch_addr = RING + 32;
      kick = 1'b1;
      @(negedge clk);
      kick = 1'b0;
      repeat (5) @(negedge clk);
      kick = 1'b1;
      @(negedge clk);
      kick = 1'b0;
      repeat (5) @(negedge clk);
      kick = 1'b1;
      @(negedge clk);
      kick = 1'b0;
      chk(busy, "R11 busy during scan", busy, 1);
      while (busy) @(negedge clk);
      repeat (3) @(negedge clk);
      chk(watch_cnt == 2, "R11 one extra scan", watch_cnt, 2);
      chk(done_cnt == 1 && cur_ptr == RING + 32, "R11 single frame", done_cnt, 1);

      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule